// File: doc/BRIEF.md
# Write-Protection Guard with Status Register

This block holds an eight-bit status byte for a byte-addressed serial memory. From that byte, the level of a write-protect pin and the target address, it decides whether an array write or a status write may proceed. A command decoder next to it sends single-cycle pulse requests: arm the write-enable latch, disarm it, or load a new status byte. For each array write it presents the 14-bit address, and it reads the two permission flags back on the same cycle.

The address space is split into four quarters by address bits 13:12, each 4096 bytes. A two-bit range code in the status byte protects nothing, the top quarter, the top half, or everything. A sticky lock bit, together with the pin, decides whether the status byte itself may be rewritten.

A power-on reset returns every bit to zero, which is the factory state. A separate power-cycle pulse models a supply loss. It clears only the latch and keeps the other bits, as non-volatile bits would be kept.

Top module: `wp_guard_top`

## Requirements
- R1: While por_n is low, and after it is released, stat_out reads 8'h00.
- R2: Bit 7 is the lock, bits 3:2 are the range code and bit 1 is the write-enable latch. Bits 6, 5, 4 and 0 are free bits: they change neither permission flag, and the block never sets bit 0 by itself.
- R3: A set_we pulse makes bit 1 read 1 on the next cycle, unless a clear is requested in the same cycle.
- R4: A clr_we pulse makes bit 1 read 0 on the next cycle, and a clear wins over a set in the same cycle.
- R5: While bit 1 is 0, both array_wr_ok and stat_wr_ok are 0.
- R6: With the latch at 1, array_wr_ok is 0 exactly when wr_addr[13:12] falls in the protected region. Range code 00 protects no quarter, 01 protects quarter 3, 10 protects quarters 2 and 3, and 11 protects all quarters.
- R7: stat_wr_ok is 1 exactly when the latch is 1 and either the lock bit is 0 or wp_pin is high.
- R8: A load_req while stat_wr_ok is 1 copies stat_in bits 7:2 and bit 0 into the register on the next cycle and leaves bit 1 unchanged.
- R9: A load_req while stat_wr_ok is 0 leaves bits 7:2 and bit 0 unchanged.
- R10: A pwr_cycle pulse clears bit 1 on the next cycle and keeps bits 7:2 and bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low, clears all bits |
| pwr_cycle | input | 1 | Pulse modelling a supply loss: clears only the latch |
| set_we | input | 1 | Pulse that arms the write-enable latch |
| clr_we | input | 1 | Pulse that disarms the write-enable latch |
| load_req | input | 1 | Pulse requesting a status byte load |
| stat_in | input | 8 | New status byte for load_req |
| wp_pin | input | 1 | Write-protect pin level, high means not protected |
| wr_addr | input | 14 | Target address of an array write |
| stat_out | output | 8 | Current status byte |
| array_wr_ok | output | 1 | Array write to wr_addr is permitted |
| stat_wr_ok | output | 1 | Status byte write is permitted |

## Verification
The assertions assume that the request inputs are single-cycle pulses, sampled at the rising edge, and that they are known whenever por_n is high. The properties on the latch exclude cycles in which a competing request targets the same bit. The bench drives every input on the falling edge and lowers every pulse one cycle later. It holds wp_pin and wr_addr steady through the cycle in which the flags are compared, so each flag is judged against the state that the previous request left behind.

// File: rtl/wp_pkg.sv
package wp_pkg;
    localparam int STAT_W = 8;

    typedef struct packed {
        logic       lock;
        logic [2:0] user_hi;
        logic [1:0] range;
        logic       wel;
        logic       user_lo;
    } stat_t;

    localparam logic [1:0] RANGE_NONE    = 2'b00;
    localparam logic [1:0] RANGE_QUARTER = 2'b01;
    localparam logic [1:0] RANGE_HALF    = 2'b10;
    localparam logic [1:0] RANGE_ALL     = 2'b11;
endpackage

// File: rtl/wp_stat_reg.sv
module wp_stat_reg
    import wp_pkg::*;
(
    input  logic  clk,
    input  logic  por_n,
    input  logic  pwr_cycle,
    input  logic  set_we,
    input  logic  clr_we,
    input  logic  load_req,
    input  logic  load_ok,
    input  stat_t din,
    output stat_t stat_q
);
    stat_t stat_d;

    always_comb begin
        stat_d = stat_q;
        if (load_req && load_ok) begin
            stat_d     = din;
            stat_d.wel = stat_q.wel;
        end
        if (set_we)
            stat_d.wel = 1'b1;
        if (clr_we || pwr_cycle)
            stat_d.wel = 1'b0;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            stat_q <= '0;
        else
            stat_q <= stat_d;
    end

    // R3: arming request sets the latch
    p_set_latch_r3: assert property (@(posedge clk) disable iff (!por_n)
        (set_we && !clr_we && !pwr_cycle) |=> stat_q.wel);

    // R4 / R10: disarm or power cycle clears the latch
    p_clr_latch_r4: assert property (@(posedge clk) disable iff (!por_n)
        (clr_we || pwr_cycle) |=> !stat_q.wel);

    // R8: permitted load copies all bits but the latch
    p_load_copy_r8: assert property (@(posedge clk) disable iff (!por_n)
        (load_req && load_ok) |=>
        (stat_q[7:2] == $past(din[7:2])) && (stat_q[0] == $past(din[0])));

    p_load_keep_wel_r8: assert property (@(posedge clk) disable iff (!por_n)
        (load_req && !set_we && !clr_we && !pwr_cycle) |=> $stable(stat_q.wel));

    // R9: refused load holds the non-latch bits
    p_refused_hold_r9: assert property (@(posedge clk) disable iff (!por_n)
        (load_req && !load_ok) |=>
        (stat_q[7:2] == $past(stat_q[7:2])) && (stat_q[0] == $past(stat_q[0])));

    // R10: power cycle keeps the non-volatile bits
    p_pwr_keep_r10: assert property (@(posedge clk) disable iff (!por_n)
        (pwr_cycle && !load_req) |=>
        (stat_q[7:2] == $past(stat_q[7:2])) && (stat_q[0] == $past(stat_q[0])));
endmodule

// File: rtl/wp_range_chk.sv
module wp_range_chk #(
    parameter int ADDR_W = 14
) (
    input  logic [1:0]        range_code,
    input  logic              wel,
    input  logic [ADDR_W-1:0] addr,
    output logic              arr_ok
);
    import wp_pkg::*;

    localparam int QSEL_LSB = ADDR_W - 2;

    logic [1:0] quarter;
    logic       prot_hit;

    assign quarter = addr[ADDR_W-1:QSEL_LSB];

    always_comb begin
        unique case (range_code)
            RANGE_NONE:    prot_hit = 1'b0;
            RANGE_QUARTER: prot_hit = (quarter == 2'b11);
            RANGE_HALF:    prot_hit = quarter[1];
            default:       prot_hit = 1'b1;
        endcase
    end

    assign arr_ok = wel && !prot_hit;
endmodule

// File: rtl/wp_stat_gate.sv
module wp_stat_gate (
    input  logic wel,
    input  logic lock,
    input  logic wp_pin,
    output logic stat_ok
);
    assign stat_ok = wel && (!lock || wp_pin);
endmodule

// File: rtl/wp_guard_top.sv
module wp_guard_top
    import wp_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              pwr_cycle,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic              load_req,
    input  logic [STAT_W-1:0] stat_in,
    input  logic              wp_pin,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [STAT_W-1:0] stat_out,
    output logic              array_wr_ok,
    output logic              stat_wr_ok
);
    stat_t stat_q;
    stat_t din;

    assign din      = stat_t'(stat_in);
    assign stat_out = stat_q;

    wp_stat_gate u_gate (
        .wel     (stat_q.wel),
        .lock    (stat_q.lock),
        .wp_pin  (wp_pin),
        .stat_ok (stat_wr_ok)
    );

    wp_stat_reg u_reg (
        .clk       (clk),
        .por_n     (por_n),
        .pwr_cycle (pwr_cycle),
        .set_we    (set_we),
        .clr_we    (clr_we),
        .load_req  (load_req),
        .load_ok   (stat_wr_ok),
        .din       (din),
        .stat_q    (stat_q)
    );

    wp_range_chk #(.ADDR_W(ADDR_W)) u_range (
        .range_code (stat_q.range),
        .wel        (stat_q.wel),
        .addr       (wr_addr),
        .arr_ok     (array_wr_ok)
    );

    // R5: disarmed latch refuses everything
    p_latch_off_r5: assert property (@(posedge clk) disable iff (!por_n)
        !stat_out[1] |-> (!array_wr_ok && !stat_wr_ok));

    // R7: locked register with pin low refuses status writes
    p_lock_pin_r7: assert property (@(posedge clk) disable iff (!por_n)
        (stat_out[7] && !wp_pin) |-> !stat_wr_ok);

    // R6: full-range code refuses every array write
    p_full_range_r6: assert property (@(posedge clk) disable iff (!por_n)
        (stat_out[3:2] == 2'b11) |-> !array_wr_ok);

    // R2: the block never raises bit 0 without a load
    p_bit0_quiet_r2: assert property (@(posedge clk) disable iff (!por_n)
        !load_req |=> $stable(stat_out[0]));
endmodule

// File: tb/wp_guard_top_test.sv
module wp_guard_top_test;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        pwr_cycle = 1'b0;
    logic        set_we = 1'b0;
    logic        clr_we = 1'b0;
    logic        load_req = 1'b0;
    logic [7:0]  stat_in = 8'h00;
    logic        wp_pin = 1'b1;
    logic [13:0] wr_addr = 14'h0000;
    logic [7:0]  stat_out;
    logic        array_wr_ok;
    logic        stat_wr_ok;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wp_guard_top uut (
        .clk(clk), .por_n(por_n), .pwr_cycle(pwr_cycle), .set_we(set_we),
        .clr_we(clr_we), .load_req(load_req), .stat_in(stat_in),
        .wp_pin(wp_pin), .wr_addr(wr_addr), .stat_out(stat_out),
        .array_wr_ok(array_wr_ok), .stat_wr_ok(stat_wr_ok)
    );

    typedef struct packed {
        logic        set;
        logic        clr;
        logic        ld;
        logic        pwr;
        logic        pin;
        logic [7:0]  din;
        logic [13:0] addr;
        logic [7:0]  e_stat;
        logic        e_aok;
        logic        e_sok;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{0,0,0,0,1,8'h00,14'h0000,8'h00,0,0}, // R5 idle after reset
        '{0,0,1,0,1,8'hFF,14'h0000,8'h00,0,0}, // R9 load refused, latch 0
        '{1,0,0,0,1,8'h00,14'h0000,8'h02,1,1}, // R3 arm
        '{0,0,1,0,1,8'h04,14'h3FFF,8'h06,0,1}, // R8 code 01, top quarter hit
        '{0,0,0,0,1,8'h00,14'h2FFF,8'h06,1,1}, // R6 quarter 2 open
        '{0,0,1,0,1,8'h08,14'h2000,8'h0A,0,1}, // R6 code 10, half hit
        '{0,0,0,0,1,8'h00,14'h1FFF,8'h0A,1,1}, // R6 lower half open
        '{0,0,1,0,1,8'h0C,14'h0000,8'h0E,0,1}, // R6 code 11 all
        '{0,0,1,0,1,8'h71,14'h3FFF,8'h73,1,1}, // R2 free bits no effect
        '{0,0,1,0,1,8'h80,14'h0000,8'h82,1,1}, // R7 locked, pin high
        '{0,0,0,0,0,8'h00,14'h0000,8'h82,1,0}, // R7 locked, pin low
        '{0,0,1,0,0,8'h0C,14'h0000,8'h82,1,0}, // R9 refused by lock
        '{0,0,1,0,1,8'h0C,14'h0000,8'h0E,0,1}, // R8 unlock with pin high
        '{0,1,0,0,1,8'h00,14'h0000,8'h0C,0,0}, // R4 disarm
        '{1,1,0,0,1,8'h00,14'h0000,8'h0C,0,0}, // R4 clear wins
        '{1,0,1,0,1,8'h00,14'h0000,8'h0E,0,1}, // R9 load uses old latch
        '{0,0,1,0,1,8'hA4,14'h0000,8'hA6,1,1}, // R8 lock + code 01
        '{0,0,0,1,1,8'h00,14'h0000,8'hA4,0,0}, // R10 power cycle
        '{1,0,0,0,0,8'h00,14'h3000,8'hA6,0,0}, // R6 top quarter, R7 pin low
        '{0,0,0,0,0,8'h00,14'h2FFF,8'hA6,1,0}  // R6 quarter 2 open
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset held", stat_out, 8'h00);
        por_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", stat_out, 8'h00);
        chk("R5 aok at reset", {7'd0, array_wr_ok}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            set_we    = VECS[i].set;
            clr_we    = VECS[i].clr;
            load_req  = VECS[i].ld;
            pwr_cycle = VECS[i].pwr;
            wp_pin    = VECS[i].pin;
            stat_in   = VECS[i].din;
            wr_addr   = VECS[i].addr;
            @(posedge clk);
            #1;
            set_we = 1'b0; clr_we = 1'b0; load_req = 1'b0; pwr_cycle = 1'b0;
            @(negedge clk);
            chk($sformatf("R2-table vec%0d stat", i), stat_out, VECS[i].e_stat);
            chk($sformatf("R6 vec%0d array_wr_ok", i), {7'd0, array_wr_ok}, {7'd0, VECS[i].e_aok});
            chk($sformatf("R7 vec%0d stat_wr_ok", i), {7'd0, stat_wr_ok}, {7'd0, VECS[i].e_sok});
        end

        // R1: reset in mid-run returns to factory state
        @(negedge clk);
        por_n = 1'b0;
        #1;
        chk("R1 mid-run reset", stat_out, 8'h00);
        @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        chk("R1 flags after reset", {6'd0, array_wr_ok, stat_wr_ok}, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule